// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they are still in the decode stage of a five-stage in-order pipeline. A dedicated adder forms the destination from the decoding instruction's PC and its sign-extended word offset, and a separate comparator checks the two source operands for equality or inequality. The ALU plays no part. When a branch resolves as taken, the block redirects the next PC and squashes the one instruction fetched behind the branch in the same cycle, so a taken branch costs exactly one cycle.

The only operand path besides the register-file outputs is a write-through bypass. A register being written back in the current cycle is passed straight to the comparator. No other forwarding exists. If the instruction in EX is an ALU op that writes one of the branch's sources, the result is not yet readable. A two-state interlock machine then stalls decode for exactly one cycle. During that cycle it holds the PC and the IF/ID register and sends a bubble into ID/EX.

The interlock machine has two states. In `IL_RUN`, branches resolve in the cycle they are decoded. The transition `RUN->HOLD` fires when a decoded branch depends on an EX-stage ALU result, and the stall outputs are asserted during that `RUN` cycle. `IL_HOLD` is the single cycle after the stall, in which the branch resolves whatever EX reports. The transition `HOLD->RUN` always fires on the next edge. The self-loop `RUN->RUN` covers every cycle without a hazard.

Top module: `id_branch_resolver`

## Requirements
- R1: `br_target` always equals `id_pc + 4 + (sign-extended id_imm shifted left by 2)`, modulo 2^32.
- R2: With `id_valid`=1 and `id_br_kind`=2'b01 (equal), and no stall, `br_taken` is 1 exactly when the two resolved operands are equal.
- R3: With `id_valid`=1 and `id_br_kind`=2'b10 (not equal), and no stall, `br_taken` is 1 exactly when the two resolved operands differ.
- R4: With `id_br_kind` 2'b00 or 2'b11, or with `id_valid`=0, `br_taken`, `pc_sel_branch`, `if_flush` and `id_stall` are all 0.
- R5: `if_flush` and `pc_sel_branch` are 1 in the same cycle that `br_taken` is 1, and 0 for a not-taken branch.
- R6: Each resolved operand equals `wb_data` when `wb_we`=1, `wb_idx` equals that source's index, and the index is nonzero. Otherwise it equals the register-file value. Index 0 is never bypassed.
- R7: A valid branch whose rs or rt index (nonzero) matches `ex_rd_idx` while `ex_alu_wr`=1 raises `id_stall`, `idex_bubble`, `pc_hold` and `ifid_hold` for exactly one cycle. `br_taken` stays 0 during that cycle.
- R8: An EX-stage write to register 0 never causes a stall.
- R9: In the cycle after a stall, the branch resolves even if the EX-stage inputs still report the same hazard.
- R10: While reset is held and no branch is presented, all outputs except `br_target` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the interlock state |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_br_kind | input | 2 | 00 none, 01 equal, 10 not equal, 11 none |
| id_pc | input | 32 | PC of the instruction in decode |
| id_imm | input | 16 | Branch word offset |
| id_rs_idx | input | 5 | First source register index |
| id_rt_idx | input | 5 | Second source register index |
| rf_rs_data | input | 32 | Register-file read value for the first source |
| rf_rt_data | input | 32 | Register-file read value for the second source |
| wb_we | input | 1 | Write-back stage writes a register this cycle |
| wb_idx | input | 5 | Write-back destination index |
| wb_data | input | 32 | Write-back value |
| ex_alu_wr | input | 1 | EX stage holds an ALU op that writes a register |
| ex_rd_idx | input | 5 | EX-stage destination index |
| br_taken | output | 1 | Branch resolved as taken this cycle |
| br_target | output | 32 | Branch destination address |
| pc_sel_branch | output | 1 | Next PC takes `br_target` |
| if_flush | output | 1 | Squash the instruction being fetched |
| id_stall | output | 1 | Decode is stalled this cycle |
| idex_bubble | output | 1 | Load a bubble into ID/EX |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep IF/ID unchanged |

## Verification
The write-back bypass and the post-stall resolution can fall in the same cycle. A branch first waits one cycle on an EX-stage producer, and in the `IL_HOLD` cycle that producer's value shows up on the write-back port while the register file still returns a stale value. The bench provokes this by changing only the write-back inputs during the hold cycle. It judges the outcome by whether `br_taken`, `if_flush` and `pc_sel_branch` reflect the bypassed value rather than the stale one, and by whether no second stall appears.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_EQ   = 2'b01,
        BK_NE   = 2'b10,
        BK_RSVD = 2'b11
    } br_kind_e;

    typedef enum logic {
        IL_RUN  = 1'b0,
        IL_HOLD = 1'b1
    } il_state_e;

    function automatic logic is_cond_branch(input br_kind_e k);
        return (k == BK_EQ) || (k == BK_NE);
    endfunction
endpackage

// File: rtl/br_target_adder.sv
module br_target_adder #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W       = XLEN - IMM_W - SHIFT;
    localparam int INSTR_BYTES = 1 << SHIFT;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
        seq_pc = pc + XLEN'(INSTR_BYTES);
        target = seq_pc + offset;
    end
endmodule

// File: rtl/br_operand_bypass.sv
module br_operand_bypass #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic [XLEN-1:0]   rf_val,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_idx,
    input  logic [XLEN-1:0]   wb_data,
    output logic [XLEN-1:0]   src_val
);
    logic hit;

    always_comb begin
        hit     = wb_we && (wb_idx == src_idx) && (src_idx != '0);
        src_val = hit ? wb_data : rf_val;
    end
endmodule

// File: rtl/br_condition_cmp.sv
module br_condition_cmp
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            cond_met
);
    logic differ;

    always_comb begin
        differ = |(op_a ^ op_b);
        unique case (kind)
            BK_EQ:   cond_met = !differ;
            BK_NE:   cond_met = differ;
            default: cond_met = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_interlock_fsm.sv
module br_interlock_fsm
    import br_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_active,
    input  logic [REG_AW-1:0] rs_idx,
    input  logic [REG_AW-1:0] rt_idx,
    input  logic              ex_alu_wr,
    input  logic [REG_AW-1:0] ex_rd_idx,
    output logic              stall
);
    il_state_e state_q, state_d;
    logic      dep_rs, dep_rt, hazard;

    always_comb begin
        dep_rs = ex_alu_wr && (ex_rd_idx != '0) && (ex_rd_idx == rs_idx);
        dep_rt = ex_alu_wr && (ex_rd_idx != '0) && (ex_rd_idx == rt_idx);
        hazard = br_active && (dep_rs || dep_rt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IL_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IL_RUN:  state_d = hazard ? IL_HOLD : IL_RUN;
            IL_HOLD: state_d = IL_RUN;
            default: state_d = IL_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IL_RUN:  stall = hazard;
            IL_HOLD: stall = 1'b0;
            default: stall = 1'b0;
        endcase
    end

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R7
    AST_HOLD_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IL_HOLD) |-> $past(stall)); // R9
    AST_ZERO_DEST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd_idx == '0) |-> !stall); // R8
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
    import br_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [1:0]        id_br_kind,
    input  logic [XLEN-1:0]   id_pc,
    input  logic [IMM_W-1:0]  id_imm,
    input  logic [REG_AW-1:0] id_rs_idx,
    input  logic [REG_AW-1:0] id_rt_idx,
    input  logic [XLEN-1:0]   rf_rs_data,
    input  logic [XLEN-1:0]   rf_rt_data,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_idx,
    input  logic [XLEN-1:0]   wb_data,
    input  logic              ex_alu_wr,
    input  logic [REG_AW-1:0] ex_rd_idx,
    output logic              br_taken,
    output logic [XLEN-1:0]   br_target,
    output logic              pc_sel_branch,
    output logic              if_flush,
    output logic              id_stall,
    output logic              idex_bubble,
    output logic              pc_hold,
    output logic              ifid_hold
);
    localparam int NSRC = 2;

    br_kind_e          kind;
    logic              br_active;
    logic              cond_met;
    logic              stall;
    logic [REG_AW-1:0] src_idx [NSRC];
    logic [XLEN-1:0]   src_rf  [NSRC];
    logic [XLEN-1:0]   src_val [NSRC];

    always_comb begin
        kind       = br_kind_e'(id_br_kind);
        br_active  = id_valid && is_cond_branch(kind);
        src_idx[0] = id_rs_idx;
        src_idx[1] = id_rt_idx;
        src_rf[0]  = rf_rs_data;
        src_rf[1]  = rf_rt_data;
    end

    br_target_adder #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(2)) u_adder (
        .pc     (id_pc),
        .imm    (id_imm),
        .target (br_target)
    );

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        br_operand_bypass #(.XLEN(XLEN), .REG_AW(REG_AW)) u_byp (
            .src_idx (src_idx[gi]),
            .rf_val  (src_rf[gi]),
            .wb_we   (wb_we),
            .wb_idx  (wb_idx),
            .wb_data (wb_data),
            .src_val (src_val[gi])
        );
    end

    br_condition_cmp #(.XLEN(XLEN)) u_cmp (
        .kind     (kind),
        .op_a     (src_val[0]),
        .op_b     (src_val[1]),
        .cond_met (cond_met)
    );

    br_interlock_fsm #(.REG_AW(REG_AW)) u_ilk (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_active (br_active),
        .rs_idx    (id_rs_idx),
        .rt_idx    (id_rt_idx),
        .ex_alu_wr (ex_alu_wr),
        .ex_rd_idx (ex_rd_idx),
        .stall     (stall)
    );

    always_comb begin
        br_taken      = br_active && !stall && cond_met;
        pc_sel_branch = br_taken;
        if_flush      = br_taken;
        id_stall      = stall;
        idex_bubble   = stall;
        pc_hold       = stall;
        ifid_hold     = stall;
    end

    AST_NO_TAKE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        id_stall |-> !br_taken); // R7
    AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        if_flush |-> (id_valid && (id_br_kind == 2'b01 || id_br_kind == 2'b10))); // R4
    AST_EQ_TAKEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && kind == BK_EQ) |-> (src_val[0] == src_val[1])); // R2
    AST_NE_TAKEN_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && kind == BK_NE) |-> (src_val[0] != src_val[1])); // R3
    AST_BYPASS_RS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_idx == id_rs_idx && id_rs_idx != '0) |-> (src_val[0] == wb_data)); // R6
    AST_ZERO_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rt_idx == '0) |-> (src_val[1] == rf_rt_data)); // R6
endmodule

// File: tb/id_branch_resolver_test.sv
module id_branch_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [1:0]  id_br_kind;
    logic [31:0] id_pc;
    logic [15:0] id_imm;
    logic [4:0]  id_rs_idx, id_rt_idx;
    logic [31:0] rf_rs_data, rf_rt_data;
    logic        wb_we;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        ex_alu_wr;
    logic [4:0]  ex_rd_idx;
    logic        br_taken, pc_sel_branch, if_flush, id_stall;
    logic        idex_bubble, pc_hold, ifid_hold;
    logic [31:0] br_target;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    id_branch_resolver uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_br_kind(id_br_kind),
        .id_pc(id_pc), .id_imm(id_imm), .id_rs_idx(id_rs_idx), .id_rt_idx(id_rt_idx),
        .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data), .wb_we(wb_we),
        .wb_idx(wb_idx), .wb_data(wb_data), .ex_alu_wr(ex_alu_wr),
        .ex_rd_idx(ex_rd_idx), .br_taken(br_taken), .br_target(br_target),
        .pc_sel_branch(pc_sel_branch), .if_flush(if_flush), .id_stall(id_stall),
        .idex_bubble(idex_bubble), .pc_hold(pc_hold), .ifid_hold(ifid_hold)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [15:0] imm);
        return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    endfunction

    task automatic idle();
        id_valid = 0; id_br_kind = 2'b00; id_pc = 32'h0; id_imm = 16'h0;
        id_rs_idx = 0; id_rt_idx = 0; rf_rs_data = 0; rf_rt_data = 0;
        wb_we = 0; wb_idx = 0; wb_data = 0; ex_alu_wr = 0; ex_rd_idx = 0;
    endtask

    task automatic branch(input logic [1:0] k, input logic [4:0] rs, input logic [31:0] a,
                          input logic [4:0] rt, input logic [31:0] b);
        id_valid = 1; id_br_kind = k;
        id_rs_idx = rs; rf_rs_data = a; id_rt_idx = rt; rf_rt_data = b;
    endtask

    task automatic expect_resolve(input string req, input logic t);
        check({req, " taken"}, {31'b0, br_taken}, {31'b0, t});
        check({req, " flush"}, {31'b0, if_flush}, {31'b0, t});
        check({req, " pcsel"}, {31'b0, pc_sel_branch}, {31'b0, t});
    endtask

    task automatic expect_stall(input string req, input logic s);
        check({req, " stall"},  {31'b0, id_stall},    {31'b0, s});
        check({req, " bubble"}, {31'b0, idex_bubble}, {31'b0, s});
        check({req, " pchold"}, {31'b0, pc_hold},     {31'b0, s});
        check({req, " ifhold"}, {31'b0, ifid_hold},   {31'b0, s});
    endtask

    task automatic t_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); #2;
        expect_resolve("R10", 1'b0);
        expect_stall("R10", 1'b0);
        rst_n = 1;
    endtask

    task automatic t_target();
        @(negedge clk); idle();
        branch(2'b01, 5'd1, 32'h5, 5'd2, 32'h5);
        id_pc = 32'h0040_0000; id_imm = 16'h0010; #2;
        check("R1 fwd", br_target, exp_target(id_pc, id_imm));
        check("R1 fwd const", br_target, 32'h0040_0044);
        id_imm = 16'hFFFE; #2;
        check("R1 back", br_target, 32'h003F_FFFC);
        id_imm = 16'h8000; #2;
        check("R1 min", br_target, 32'h003E_0004);
        id_pc = 32'hFFFF_FFF0; id_imm = 16'h0008; #2;
        check("R1 wrap", br_target, exp_target(id_pc, id_imm));
    endtask

    task automatic t_eq();
        @(negedge clk); idle();
        branch(2'b01, 5'd3, 32'hDEAD_BEEF, 5'd4, 32'hDEAD_BEEF); #2;
        expect_resolve("R2 R5 eq equal", 1'b1);
        rf_rt_data = 32'hDEAD_BEEE; #2;
        expect_resolve("R2 R5 eq differ", 1'b0);
    endtask

    task automatic t_ne();
        @(negedge clk); idle();
        branch(2'b10, 5'd3, 32'h8000_0000, 5'd4, 32'h0); #2;
        expect_resolve("R3 ne differ", 1'b1);
        rf_rt_data = 32'h8000_0000; #2;
        expect_resolve("R3 ne equal", 1'b0);
    endtask

    task automatic t_nonbranch();
        @(negedge clk); idle();
        branch(2'b00, 5'd3, 32'h1, 5'd4, 32'h1);
        ex_alu_wr = 1; ex_rd_idx = 5'd3; #2;
        expect_resolve("R4 kind none", 1'b0);
        check("R4 none stall", {31'b0, id_stall}, 32'h0);
        id_br_kind = 2'b11; #2;
        expect_resolve("R4 kind rsvd", 1'b0);
        check("R4 rsvd stall", {31'b0, id_stall}, 32'h0);
        id_br_kind = 2'b01; id_valid = 0; #2;
        expect_resolve("R4 invalid", 1'b0);
        check("R4 invalid stall", {31'b0, id_stall}, 32'h0);
    endtask

    task automatic t_bypass();
        @(negedge clk); idle();
        branch(2'b01, 5'd5, 32'h1, 5'd6, 32'h7);
        wb_we = 1; wb_idx = 5'd5; wb_data = 32'h7; #2;
        expect_resolve("R6 bypass rs", 1'b1);
        wb_we = 0; #2;
        expect_resolve("R6 no we", 1'b0);
        branch(2'b10, 5'd9, 32'h4, 5'd10, 32'h3);
        wb_we = 1; wb_idx = 5'd10; wb_data = 32'h4; #2;
        expect_resolve("R6 bypass rt", 1'b0);
        branch(2'b01, 5'd0, 32'h0, 5'd7, 32'h0);
        wb_idx = 5'd0; wb_data = 32'h55; #2;
        expect_resolve("R6 reg0 ignored", 1'b1);
    endtask

    task automatic t_stall();
        @(negedge clk); idle();
        branch(2'b01, 5'd8, 32'h2, 5'd9, 32'h2);
        ex_alu_wr = 1; ex_rd_idx = 5'd9; #2;
        expect_stall("R7 first", 1'b1);
        expect_resolve("R7 first", 1'b0);
        @(posedge clk); #2;
        expect_stall("R7 R9 after", 1'b0);
        expect_resolve("R9 resolve", 1'b1);
        @(negedge clk); idle(); #2;
        expect_stall("R7 idle", 1'b0);
    endtask

    task automatic t_zero();
        @(negedge clk); idle();
        branch(2'b10, 5'd0, 32'h0, 5'd2, 32'h1);
        ex_alu_wr = 1; ex_rd_idx = 5'd0; #2;
        expect_stall("R8 reg0", 1'b0);
        expect_resolve("R8 resolves", 1'b1);
    endtask

    task automatic t_stall_bypass();
        @(negedge clk); idle();
        branch(2'b10, 5'd12, 32'h10, 5'd13, 32'h10);
        ex_alu_wr = 1; ex_rd_idx = 5'd12; #2;
        expect_stall("R7 combo", 1'b1);
        @(posedge clk); #2;
        wb_we = 1; wb_idx = 5'd12; wb_data = 32'h11; #2;
        expect_stall("R9 combo", 1'b0);
        expect_resolve("R6 R9 combo", 1'b1);
        @(negedge clk); idle();
    endtask

    initial begin
        t_reset();
        t_target();
        t_eq();
        t_ne();
        t_nonbranch();
        t_bypass();
        t_stall();
        t_zero();
        t_stall_bypass();
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule